// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Control Core

This block is the digital half of an 8-bit serial converter. An external host selects the device with an active-low chip select and toggles a slow serial clock. On the serial data input it sends a logic-1 start bit and then a short word that routes the analogue multiplexer. The core decodes that word into channel-enable lines. A set number of serial clocks later it runs a successive-approximation search. The search drives a trial code to an external DAC and reads back one comparator bit for each step.

Each decision goes out on the data output as soon as it is made, most significant bit first. Once the search ends, the same result is sent out again least significant bit first. An active-low shift-enable input can hold this second stream. A status output is high while the search runs. Raising chip select returns the core to its idle state and takes both outputs off the wire.

The whole core runs on one fast system clock. It oversamples the serial clock, chip select, data input and shift enable through synchronizers. Serial-clock edges become single-cycle events, so the events spaced half a serial period apart are handled as ordinary synchronous updates.

Top module: `sar_adc_serial_ctrl`

## Requirements
- R1: While chip select is low and no start bit has been seen, the data output is not driven (`dout_oe`=0), the status output is driven low (`status_oe`=1, `status`=0), and logic-0 bits on the data input are skipped.
- R2: After the start bit, the next CFG_BITS bits are sampled on rising serial-clock edges. The first is the mode (1 = single-ended, 0 = differential), the second is the odd flag, and the rest form the pair select, most significant bit first. The positive channel index is {select, odd}. In differential mode the negative channel is {select, ~odd} and `com_en`=0. In single-ended mode no negative channel is enabled and `com_en`=1. The enables are valid before the next falling edge and stay stable until chip select rises.
- R3: On the falling serial-clock edge that follows the last configuration bit, the status output goes high and the data output is enabled and driven low. `dac_code` takes the first trial value 0x80.
- R4: Each of the next 8 falling edges decides one result bit, most significant bit first. The trial bit is kept when `cmp`=1 and dropped when `cmp`=0. The decision appears on the data output at that edge, and the next lower trial bit is added to `dac_code`. After the eighth decision, `dac_code` holds the result.
- R5: The status output falls on the first rising serial-clock edge after the eighth decision.
- R6: The least significant bit shown at the end of the search is not sent twice. Each later falling edge with shift enable low shows result bits 1 through 7 in turn.
- R7: A falling edge that sees shift enable high leaves the data output unchanged.
- R8: After bit 7 of the second stream, the next enabled falling edge drives the data output low, and it stays low until chip select rises.
- R9: The data input is ignored from the end of the configuration word until chip select rises. Toggling it changes neither the result nor the enables, and it cannot start a new search.
- R10: Chip select high clears all state: outputs undriven, enables zero, `dac_code` zero. Only a later falling chip select can begin a new transfer.
- R11: During reset every output is zero and neither output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data input |
| se_n | input | 1 | Active-low enable for the least-significant-first stream |
| cmp | input | 1 | Comparator: 1 when the analogue input is at or above the DAC level |
| dac_code | output | RES_BITS | Trial code for the external DAC |
| pos_en | output | 2**(CFG_BITS-1) | One-hot enable of the positive multiplexer input |
| neg_en | output | 2**(CFG_BITS-1) | Enable of the negative multiplexer input (differential mode) |
| com_en | output | 1 | Common terminal used as negative input |
| dout | output | 1 | Serial data output value |
| dout_oe | output | 1 | Drive enable of the data output |
| status | output | 1 | Conversion-in-progress output value |
| status_oe | output | 1 | Drive enable of the status output |

## Verification
Every transfer is checked against a comparator model, `cmp = vin >= dac_code`, so the search should return `vin` exactly. The sweep covers codes 0x00, 0xFF and spread values, and walks through all sixteen configuration words, which separates each positive and negative channel and both modes. Some transfers hold shift enable high for one or two falling edges, showing that the gate stalls the second stream rather than dropping a bit. Other transfers toggle the data input during and after the search, and send a late start bit before chip select rises, to show that no input is taken outside the addressing window.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_CONV   = 3'd3,
    ST_LSB    = 3'd4,
    ST_TAIL   = 3'd5
  } ctl_state_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int             WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/mux_route_decode.sv
module mux_route_decode #(
  parameter int CFG_BITS = 4,
  localparam int NCH     = 2 ** (CFG_BITS - 1),
  localparam int IDX_W   = CFG_BITS - 1
) (
  input  logic [CFG_BITS-1:0] cfg,
  output logic [NCH-1:0]      pos_en,
  output logic [NCH-1:0]      neg_en,
  output logic                com_en
);

  logic             single_ended;
  logic [IDX_W-1:0] pos_idx;
  logic [IDX_W-1:0] neg_idx;

  assign single_ended = cfg[CFG_BITS-1];
  assign pos_idx      = {cfg[CFG_BITS-3:0],  cfg[CFG_BITS-2]};
  assign neg_idx      = {cfg[CFG_BITS-3:0], ~cfg[CFG_BITS-2]};
  assign com_en       = single_ended;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign pos_en[ch] = (pos_idx == IDX_W'(ch));
    assign neg_en[ch] = ~single_ended & (neg_idx == IDX_W'(ch));
  end

endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                start,
  input  logic                step,
  input  logic                cmp,
  output logic [RES_BITS-1:0] code,
  output logic                last_trial
);

  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] code_q, code_d;
  logic [RES_BITS-1:0] mask_q, mask_d;

  always_comb begin
    code_d = code_q;
    mask_d = mask_q;
    if (clr) begin
      code_d = '0;
      mask_d = '0;
    end else if (start) begin
      code_d = TOP_BIT;
      mask_d = TOP_BIT;
    end else if (step) begin
      code_d = (cmp ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  assign code       = code_q;
  assign last_trial = mask_q[0];

  AST_SAR_ONE_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q)); // R4

  AST_SAR_KEEP_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !start) |=> (((code_q & $past(mask_q)) != '0) == $past(cmp))); // R4

endmodule

// File: rtl/sar_adc_serial_ctrl.sv
module sar_adc_serial_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int CFG_BITS     = 4,
  parameter int RES_BITS     = 8,
  parameter bit USE_SHIFT_EN = 1'b1,
  localparam int NCH         = 2 ** (CFG_BITS - 1),
  localparam int CNT_MAX     = (CFG_BITS > RES_BITS) ? CFG_BITS : RES_BITS,
  localparam int CNT_W       = $clog2(CNT_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                din,
  input  logic                se_n,
  input  logic                cmp,
  output logic [RES_BITS-1:0] dac_code,
  output logic [NCH-1:0]      pos_en,
  output logic [NCH-1:0]      neg_en,
  output logic                com_en,
  output logic                dout,
  output logic                dout_oe,
  output logic                status,
  output logic                status_oe
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // pin synchronizers: {sclk, cs_n, din, se_n}
  logic [3:0] pins_s;
  logic       s_sclk, s_cs_n, s_din, s_se_n;

  pin_sync #(.WIDTH(4), .RST_VAL(4'b0101)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({sclk, cs_n, din, se_n}),
    .q     (pins_s)
  );

  assign {s_sclk, s_cs_n, s_din, s_se_n} = pins_s;

  logic sclk_d_q;
  logic rise, fall, cs_clr, adv;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sclk_d_q <= 1'b0;
    else             sclk_d_q <= s_sclk;
  end

  assign rise   =  s_sclk & ~sclk_d_q;
  assign fall   = ~s_sclk &  sclk_d_q;
  assign cs_clr =  s_cs_n;

  if (USE_SHIFT_EN) begin : g_se
    assign adv = ~s_se_n;
  end else begin : g_no_se
    logic unused_se;
    assign unused_se = s_se_n;
    assign adv       = 1'b1;
  end

  // state
  ctl_state_t          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CFG_BITS-1:0] cfg_q, cfg_d, cfg_shift;
  logic [RES_BITS-1:0] sh_q, sh_d;
  logic                dout_q, dout_d, doe_q, doe_d;
  logic                sts_q, sts_d, soe_q, soe_d;
  logic [NCH-1:0]      pos_q, pos_d, neg_q, neg_d;
  logic                com_q, com_d;
  logic [NCH-1:0]      dec_pos, dec_neg;
  logic                dec_com;
  logic                sar_start, sar_step, sar_last;

  assign cfg_shift = {cfg_q[CFG_BITS-2:0], s_din};

  mux_route_decode #(.CFG_BITS(CFG_BITS)) u_decode (
    .cfg    (cfg_shift),
    .pos_en (dec_pos),
    .neg_en (dec_neg),
    .com_en (dec_com)
  );

  assign sar_start = ~cs_clr & fall & (state_q == ST_SETTLE);
  assign sar_step  = ~cs_clr & fall & (state_q == ST_CONV);

  sar_step_engine #(.RES_BITS(RES_BITS)) u_sar (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (cs_clr),
    .start      (sar_start),
    .step       (sar_step),
    .cmp        (cmp),
    .code       (dac_code),
    .last_trial (sar_last)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    sh_d    = sh_q;
    dout_d  = dout_q;
    doe_d   = doe_q;
    sts_d   = sts_q;
    soe_d   = soe_q;
    pos_d   = pos_q;
    neg_d   = neg_q;
    com_d   = com_q;
    if (cs_clr) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      cfg_d   = '0;
      sh_d    = '0;
      dout_d  = 1'b0;
      doe_d   = 1'b0;
      sts_d   = 1'b0;
      soe_d   = 1'b0;
      pos_d   = '0;
      neg_d   = '0;
      com_d   = 1'b0;
    end else begin
      soe_d = 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (rise && s_din) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
          end
        end
        ST_ADDR: begin
          if (rise) begin
            cfg_d = cfg_shift;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CFG_BITS - 1)) begin
              state_d = ST_SETTLE;
              pos_d   = dec_pos;
              neg_d   = dec_neg;
              com_d   = dec_com;
            end
          end
        end
        ST_SETTLE: begin
          if (fall) begin
            state_d = ST_CONV;
            sts_d   = 1'b1;
            doe_d   = 1'b1;
            dout_d  = 1'b0;
          end
        end
        ST_CONV: begin
          if (fall) begin
            dout_d = cmp;
            sh_d   = {sh_q[RES_BITS-2:0], cmp};
            if (sar_last) begin
              state_d = ST_LSB;
              cnt_d   = '0;
            end
          end
        end
        ST_LSB: begin
          if (rise) sts_d = 1'b0;
          if (fall && adv) begin
            if (cnt_q == CNT_W'(RES_BITS - 1)) begin
              dout_d  = 1'b0;
              state_d = ST_TAIL;
            end else begin
              dout_d = sh_q[1];
              sh_d   = sh_q >> 1;
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        ST_TAIL: dout_d = 1'b0;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cfg_q   <= '0;
      sh_q    <= '0;
      dout_q  <= 1'b0;
      doe_q   <= 1'b0;
      sts_q   <= 1'b0;
      soe_q   <= 1'b0;
      pos_q   <= '0;
      neg_q   <= '0;
      com_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
      sh_q    <= sh_d;
      dout_q  <= dout_d;
      doe_q   <= doe_d;
      sts_q   <= sts_d;
      soe_q   <= soe_d;
      pos_q   <= pos_d;
      neg_q   <= neg_d;
      com_q   <= com_d;
    end
  end

  assign dout      = dout_q;
  assign dout_oe   = doe_q;
  assign status    = sts_q;
  assign status_oe = soe_q;
  assign pos_en    = pos_q;
  assign neg_en    = neg_q;
  assign com_en    = com_q;

  AST_DRIVE_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(doe_q) |-> sts_q); // R3

  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sts_q && $past(sts_q)) |-> ($stable(pos_q) && $stable(neg_q) && $stable(com_q))); // R2

  AST_NEG_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(neg_q) && $onehot0(pos_q)); // R2

  AST_COM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    com_q |-> (neg_q == '0)); // R2

  AST_STATUS_DROP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sts_q) && !$past(cs_clr) |-> $past(rise)); // R5

  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(cs_clr) |-> (!doe_q && !soe_q && (pos_q == '0))); // R10

endmodule

// File: tb/sar_adc_serial_ctrl_test.sv
module sar_adc_serial_ctrl_test;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic se_n = 1'b0;
  logic [7:0] vin = 8'd0;

  logic       cmp;
  logic [7:0] dac_code;
  logic [7:0] pos_en, neg_en;
  logic       com_en, dout, dout_oe, status, status_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign cmp = (vin >= dac_code);

  sar_adc_serial_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .se_n(se_n), .cmp(cmp), .dac_code(dac_code), .pos_en(pos_en),
    .neg_en(neg_en), .com_en(com_en), .dout(dout), .dout_oe(dout_oe),
    .status(status), .status_oe(status_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic up();
    sclk = 1'b1;
    hp();
  endtask

  task automatic dn();
    sclk = 1'b0;
    hp();
  endtask

  task automatic check_mux(input string req, input logic [3:0] cfg);
    logic [2:0] pidx;
    logic [7:0] pexp, nexp;
    pidx = {cfg[1:0], cfg[2]};
    pexp = 8'(1 << pidx);
    nexp = cfg[3] ? 8'h00 : 8'(1 << (pidx ^ 3'd1));
    chk({req, " pos_en"}, 32'(pos_en), 32'(pexp));
    chk({req, " neg_en"}, 32'(neg_en), 32'(nexp));
    chk({req, " com_en"}, 32'(com_en), 32'(cfg[3]));
  endtask

  task automatic conv(input logic [3:0] cfg, input logic [7:0] v, input int se_hold, input bit junk);
    vin  = v;
    din  = 1'b0;
    cs_n = 1'b0;
    dn();
    repeat (2) begin
      din = 1'b0;
      up();
      dn();
    end
    chk("R1 dout_oe before start", 32'(dout_oe), 0);
    chk("R1 status_oe", 32'(status_oe), 1);
    chk("R1 status low", 32'(status), 0);
    din = 1'b1;
    up();
    dn();
    for (int i = 3; i >= 0; i--) begin
      din = cfg[i];
      up();
      if (i > 0) dn();
    end
    check_mux("R2", cfg);
    chk("R2 status low in settle", 32'(status), 0);
    chk("R2 dout_oe in settle", 32'(dout_oe), 0);
    dn();
    chk("R3 status high", 32'(status), 1);
    chk("R3 dout_oe", 32'(dout_oe), 1);
    chk("R3 dout low", 32'(dout), 0);
    chk("R3 first trial", 32'(dac_code), 32'h80);
    for (int k = 7; k >= 0; k--) begin
      if (junk) din = 1'($urandom);
      up();
      dn();
      chk("R4 R9 msb-first bit", 32'(dout), 32'(v[k]));
    end
    chk("R4 final dac_code", 32'(dac_code), 32'(v));
    chk("R5 status before rise", 32'(status), 1);
    se_n = (se_hold > 0);
    up();
    chk("R5 status fell", 32'(status), 0);
    chk("R6 lsb shown", 32'(dout), 32'(v[0]));
    for (int h = 0; h < se_hold; h++) begin
      dn();
      chk("R7 held by shift enable", 32'(dout), 32'(v[0]));
      if (h == se_hold - 1) se_n = 1'b0;
      up();
    end
    for (int b = 1; b < 8; b++) begin
      if (junk) din = 1'($urandom);
      dn();
      chk("R6 lsb-first bit", 32'(dout), 32'(v[b]));
      up();
    end
    dn();
    chk("R8 tail low", 32'(dout), 0);
    din = 1'b1;
    up();
    dn();
    chk("R8 tail still low", 32'(dout), 0);
    chk("R9 no restart status", 32'(status), 0);
    chk("R9 dout still driven", 32'(dout_oe), 1);
    check_mux("R9", cfg);
    cs_n = 1'b1;
    din  = 1'b0;
    hp();
    chk("R10 dout_oe off", 32'(dout_oe), 0);
    chk("R10 status_oe off", 32'(status_oe), 0);
    chk("R10 pos_en cleared", 32'(pos_en), 0);
    chk("R10 dac cleared", 32'(dac_code), 0);
    hp();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R11 reset dout_oe", 32'(dout_oe), 0);
    chk("R11 reset status_oe", 32'(status_oe), 0);
    chk("R11 reset dac_code", 32'(dac_code), 0);
    chk("R11 reset pos_en", 32'(pos_en), 0);
    rst_n = 1'b1;
    hp();
    for (int i = 0; i < 66; i++) begin
      logic [7:0] v;
      if (i == 0)      v = 8'h00;
      else if (i == 1) v = 8'hFF;
      else             v = 8'((i * 37 + i / 3) % 256);
      conv(4'(i % 16), v, i % 3, i[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule